// File: doc/BRIEF.md
# ADC Result Averaging and Offset Stage

This block sits between the conversion sequencer and the compare stage of an analog-to-digital converter. It receives raw 12-bit conversion words with a valid strobe. With averaging turned on it sums a set of consecutive samples and forms one averaged word per set. Every word, averaged or direct, then gets a signed offset correction and lands in a result register. The register has a guard against overwriting data that has not yet been read.

The offset is given as a 12-bit magnitude plus a direction bit. The corrected value is clamped to the 12-bit code range. A one-cycle strobe tells the compare stage that the register has just taken a new value. A level flag shows that an unread result is waiting, and a read strobe clears it. When overwrite is disabled, a waiting result is protected: newer results are dropped until the register has been read.

Top module: `adc_result_stage`

## Requirements
- R1: With averaging disabled, each raw strobe produces a stored result on the following clock edge, and `res_valid` is high for exactly that one cycle.
- R2: With averaging enabled, set-size code 0, 1, 2 or 3 yields one result after 4, 8, 16 or 32 raw samples respectively; earlier samples of the set produce no `res_valid`.
- R3: The averaged value is the sum of the set's samples divided by the set size, rounded toward zero.
- R4: The set-size code is captured at the first sample of a set; changing it mid-set does not change where that set ends.
- R5: With `ofs_sub` = 0 the offset magnitude is added to the raw or averaged value.
- R6: With `ofs_sub` = 1 the offset magnitude is subtracted from the raw or averaged value.
- R7: A subtraction that would fall below zero yields 0.
- R8: An addition that would exceed 4095 yields 4095.
- R9: With `ovwr_en` = 0 and an unread result held, a new result is discarded: `result` keeps its value and `res_valid` stays low.
- R10: With `ovwr_en` = 1 every new result replaces the register contents, whether or not they were read.
- R11: A read strobe clears `done` and lets the next result be stored. If a read and a new result arrive in the same cycle, the new result is stored and `done` stays 1.
- R12: Reset (synchronous, active low) sets `result` to 0 and `done` and `res_valid` to 0, and discards any partial averaging sum.
- R13: Deasserting `avg_en` discards a partially accumulated set, so the next averaged set starts from an empty sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_valid | input | 1 | Raw conversion word present this cycle |
| raw_data | input | 12 | Raw conversion word |
| avg_en | input | 1 | Averaging on |
| avg_sel | input | 2 | Set-size code (0:4, 1:8, 2:16, 3:32 samples) |
| ofs_mag | input | 12 | Offset correction magnitude |
| ofs_sub | input | 1 | 0 adds the offset, 1 subtracts it |
| ovwr_en | input | 1 | 1 lets new results replace unread ones |
| rd_strobe | input | 1 | Result register has been read |
| result | output | 12 | Result register |
| res_valid | output | 1 | One-cycle strobe: result just updated |
| done | output | 1 | Unread result waiting |

## Verification
The bench aims at the clamp edges: subtraction below zero, an addition exactly reaching and passing full scale, and equal value and offset. A design that wraps instead of clamping would return values near 4095 or near 0. For averaging it checks truncation with a sum that is not a multiple of the set size, checks that no strobe appears one sample before a set ends, and checks a set whose size code changes after its first sample; a design that re-reads the code live would end that set late. It also covers a read that coincides with a new result, a partial set abandoned by turning averaging off, and a reset in mid-set. A design that lost the protected result, kept a stale partial sum, or cleared the flag on the coincident read would each give a wrong value or flag.

// File: rtl/adc_res_pkg.sv
// Package: shared constants for the result averaging and offset stage.
// Assumes a 12-bit converter and a 2-bit set-size code over sizes 4..32.
package adc_res_pkg;
    localparam int RES_W      = 12;  // result and raw word width
    localparam int AVG_SEL_W  = 2;   // width of the set-size code
    localparam int AVG_MIN_LG = 2;   // log2 of the smallest set (4)
endpackage

// File: rtl/adc_avg_accum.sv
// Module: averaging accumulator.
// Passes raw words straight through when averaging is off. When on, sums
// 2**(MIN_LG+code) samples and emits sum >> (MIN_LG+code) on the last one.
// Assumes the set-size code is sampled at the first sample of each set.
module adc_avg_accum #(
    parameter int DATA_W = adc_res_pkg::RES_W,
    parameter int SEL_W  = adc_res_pkg::AVG_SEL_W,
    parameter int MIN_LG = adc_res_pkg::AVG_MIN_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              avg_en,
    input  logic [SEL_W-1:0]  avg_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int MAX_LG = MIN_LG + (1 << SEL_W) - 1;
    localparam int ACC_W  = DATA_W + MAX_LG;
    localparam int CNT_W  = MAX_LG;
    localparam int SH_W   = $clog2(MAX_LG + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [ACC_W-1:0] acc_q;
    logic [SEL_W-1:0] sel_eff;
    logic [SH_W-1:0]  shift;
    logic [CNT_W-1:0] last_idx;
    logic [ACC_W-1:0] sum;
    logic             set_end;

    // Decode the active set size and the running sum including this sample.
    always_comb begin
        sel_eff  = (cnt_q == '0) ? avg_sel : sel_q;
        shift    = SH_W'(MIN_LG) + SH_W'(sel_eff);
        last_idx = CNT_W'((32'd1 << shift) - 32'd1);
        sum      = acc_q + ACC_W'(raw_data);
        set_end  = raw_valid && (cnt_q == last_idx);
    end

    // Select the direct word or the averaged word toward the offset stage.
    always_comb begin
        if (!avg_en) begin
            out_valid = raw_valid;
            out_data  = raw_data;
        end else begin
            out_valid = set_end;
            out_data  = DATA_W'(sum >> shift);
        end
    end

    // Advance the sample count, sum and captured code of the current set.
    always_ff @(posedge clk) begin
        if (!rst_n || !avg_en) begin
            cnt_q <= '0;
            acc_q <= '0;
            sel_q <= '0;
        end else if (raw_valid) begin
            if (cnt_q == '0)
                sel_q <= avg_sel;
            if (set_end) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= sum;
            end
        end
    end

    assert_code_captured_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_en && raw_valid && cnt_q == '0) |=> (sel_q == $past(avg_sel)));

    assert_set_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_en && out_valid) |=> (cnt_q == '0 && acc_q == '0));

    assert_partial_dropped_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!avg_en) |=> (cnt_q == '0 && acc_q == '0));
endmodule

// File: rtl/adc_ofs_corr.sv
// Module: sign-magnitude offset correction with clamping.
// Adds or subtracts a magnitude and clamps the result to 0..2**DATA_W-1.
// Purely combinational; assumes the caller registers the output.
module adc_ofs_corr #(
    parameter int DATA_W = adc_res_pkg::RES_W
) (
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] ofs_mag,
    input  logic              ofs_sub,
    output logic [DATA_W-1:0] out_data
);
    localparam int EXT_W = DATA_W + 2;
    localparam logic signed [EXT_W-1:0] FULL = EXT_W'((1 << DATA_W) - 1);

    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] m_ext;
    logic signed [EXT_W-1:0] raw_sum;

    // Form the signed corrected value and clamp it to the code range.
    always_comb begin
        a_ext   = $signed({2'b00, in_data});
        m_ext   = $signed({2'b00, ofs_mag});
        raw_sum = ofs_sub ? (a_ext - m_ext) : (a_ext + m_ext);
        if (raw_sum < 0)
            out_data = '0;
        else if (raw_sum > FULL)
            out_data = '1;
        else
            out_data = raw_sum[DATA_W-1:0];
    end
endmodule

// File: rtl/adc_result_reg.sv
// Module: result register with overwrite protection.
// Stores a corrected word unless an unread one is held with overwrite off.
// A read in the same cycle as a new word frees the register for that word.
module adc_result_reg #(
    parameter int DATA_W = adc_res_pkg::RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ovwr_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] result,
    output logic              res_valid,
    output logic              done
);
    logic store;

    // Decide whether the incoming word may take the register.
    always_comb store = in_valid && (ovwr_en || !done || rd_strobe);

    // Update data, the update strobe and the unread flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            res_valid <= store;
            if (store)
                result <= in_data;
            done <= store || (done && !rd_strobe);
        end
    end

    assert_keep_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovwr_en && done && !rd_strobe) |=> ($stable(result) && !res_valid));

    assert_replace_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovwr_en) |=> (res_valid && result == $past(in_data)));

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !in_valid) |=> !done);
endmodule

// File: rtl/adc_result_stage.sv
// Module: top of the averaging, offset and result stage.
// Chains accumulator -> offset correction -> result register; one register
// stage in total, so a completing raw word shows at the outputs next cycle.
module adc_result_stage #(
    parameter int DATA_W = adc_res_pkg::RES_W,
    parameter int SEL_W  = adc_res_pkg::AVG_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              avg_en,
    input  logic [SEL_W-1:0]  avg_sel,
    input  logic [DATA_W-1:0] ofs_mag,
    input  logic              ofs_sub,
    input  logic              ovwr_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] result,
    output logic              res_valid,
    output logic              done
);
    localparam logic [DATA_W:0] FULL = {1'b0, {DATA_W{1'b1}}};

    logic              avg_valid;
    logic [DATA_W-1:0] avg_data;
    logic [DATA_W-1:0] corr_data;

    adc_avg_accum #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_valid (raw_valid),
        .raw_data  (raw_data),
        .avg_en    (avg_en),
        .avg_sel   (avg_sel),
        .out_valid (avg_valid),
        .out_data  (avg_data)
    );

    adc_ofs_corr #(.DATA_W(DATA_W)) u_ofs (
        .in_data  (avg_data),
        .ofs_mag  (ofs_mag),
        .ofs_sub  (ofs_sub),
        .out_data (corr_data)
    );

    adc_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (avg_valid),
        .in_data   (corr_data),
        .ovwr_en   (ovwr_en),
        .rd_strobe (rd_strobe),
        .result    (result),
        .res_valid (res_valid),
        .done      (done)
    );

    assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_sub && avg_data < ofs_mag) |-> (corr_data == '0));

    assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ofs_sub && ({1'b0, avg_data} + {1'b0, ofs_mag}) > FULL) |-> (corr_data == FULL[DATA_W-1:0]));
endmodule

// File: tb/tb_adc_result_stage.sv
`timescale 1ns/1ps
module tb_adc_result_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_valid = 1'b0;
    logic [11:0] raw_data = '0;
    logic        avg_en = 1'b0;
    logic [1:0]  avg_sel = '0;
    logic [11:0] ofs_mag = '0;
    logic        ofs_sub = 1'b0;
    logic        ovwr_en = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [11:0] result;
    logic        res_valid;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_result_stage dut (
        .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
        .avg_en(avg_en), .avg_sel(avg_sel), .ofs_mag(ofs_mag), .ofs_sub(ofs_sub),
        .ovwr_en(ovwr_en), .rd_strobe(rd_strobe), .result(result),
        .res_valid(res_valid), .done(done)
    );

    // raw, offset magnitude, subtract, expected result
    typedef struct packed {
        logic [11:0] raw;
        logic [11:0] mag;
        logic        sub;
        logic [11:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        {12'd100,  12'd5,    1'b0, 12'd105},
        {12'd100,  12'd5,    1'b1, 12'd95},
        {12'd3,    12'd10,   1'b1, 12'd0},
        {12'd4090, 12'd10,   1'b0, 12'd4095},
        {12'd4090, 12'd5,    1'b0, 12'd4095},
        {12'd0,    12'd4095, 1'b0, 12'd4095},
        {12'd10,   12'd10,   1'b1, 12'd0},
        {12'd2048, 12'd2048, 1'b0, 12'd4095}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One raw word, optionally with a read in the same cycle; outputs are
    // settled at the following falling edge.
    task automatic send(input logic [11:0] v, input logic rd);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_data  = v;
        rd_strobe = rd;
        @(negedge clk);
        raw_valid = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset result", result, 0);
        check("R12 reset done", done, 0);
        check("R12 reset res_valid", res_valid, 0);
        rst_n = 1'b1;

        // Table walk: direct conversions with offset add/sub and clamping.
        for (int i = 0; i < 8; i++) begin
            ofs_mag = VECS[i].mag;
            ofs_sub = VECS[i].sub;
            send(VECS[i].raw, 1'b0);
            check("R1 strobe", res_valid, 1);
            check("R5/R6/R7/R8 value", result, VECS[i].exp);
            @(negedge clk);
            check("R1 strobe one cycle", res_valid, 0);
        end
        ofs_mag = '0;
        ofs_sub = 1'b0;
        do_read();
        check("R11 read clears", done, 0);

        // Averaging, 4 samples: 100..103 -> 406/4 = 101.
        avg_en = 1'b1;
        avg_sel = 2'd0;
        for (int i = 0; i < 3; i++) send(12'(100 + i), 1'b0);
        check("R2 no early result", res_valid, 0);
        send(12'd103, 1'b0);
        check("R2 set of 4", res_valid, 1);
        check("R3 truncated average", result, 101);

        // 8 samples: 1000..1007 -> 8028/8 = 1003.
        avg_sel = 2'd1;
        for (int i = 0; i < 7; i++) send(12'(1000 + i), 1'b0);
        check("R2 no result at 7 of 8", res_valid, 0);
        send(12'd1007, 1'b0);
        check("R2 set of 8", res_valid, 1);
        check("R3 average of 8", result, 1003);

        // 32 samples: i*100 -> 49600/32 = 1550.
        avg_sel = 2'd3;
        for (int i = 0; i < 31; i++) send(12'(i * 100), 1'b0);
        check("R2 no result at 31 of 32", res_valid, 0);
        send(12'd3100, 1'b0);
        check("R2 set of 32", res_valid, 1);
        check("R3 average of 32", result, 1550);

        // 16 samples of 50 with subtracted offset 20 -> 30.
        avg_sel = 2'd2;
        ofs_mag = 12'd20;
        ofs_sub = 1'b1;
        for (int i = 0; i < 16; i++) send(12'd50, 1'b0);
        check("R6 averaged minus offset", result, 30);
        ofs_mag = '0;
        ofs_sub = 1'b0;

        // Code changes after first sample: set still ends at 4, 101/4 = 25.
        avg_sel = 2'd0;
        send(12'd10, 1'b0);
        avg_sel = 2'd3;
        send(12'd20, 1'b0);
        send(12'd30, 1'b0);
        send(12'd41, 1'b0);
        check("R4 captured code ends set", res_valid, 1);
        check("R4 captured code value", result, 25);

        // Abandon a partial set, take a direct word, then a clean set.
        avg_sel = 2'd0;
        send(12'd4000, 1'b0);
        send(12'd4000, 1'b0);
        avg_en = 1'b0;
        send(12'd77, 1'b0);
        check("R13 direct word while off", result, 77);
        avg_en = 1'b1;
        for (int i = 0; i < 4; i++) send(12'd8, 1'b0);
        check("R13 partial sum discarded", result, 8);

        // Overwrite protection.
        avg_en = 1'b0;
        ovwr_en = 1'b0;
        do_read();
        send(12'd500, 1'b0);
        check("R9 first stored", result, 500);
        send(12'd600, 1'b0);
        check("R9 no strobe when blocked", res_valid, 0);
        check("R9 unread kept", result, 500);
        do_read();
        check("R11 read clears done", done, 0);
        send(12'd700, 1'b0);
        check("R11 stored after read", result, 700);
        ovwr_en = 1'b1;
        send(12'd800, 1'b0);
        check("R10 unread replaced", result, 800);
        ovwr_en = 1'b0;
        send(12'd900, 1'b1);
        check("R11 read with new word stores", result, 900);
        check("R11 done stays set", done, 1);

        // Reset in mid-set discards the partial sum.
        ovwr_en = 1'b1;
        avg_en = 1'b1;
        avg_sel = 2'd0;
        send(12'd3000, 1'b0);
        send(12'd3000, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset clears result", result, 0);
        check("R12 reset clears done", done, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) send(12'd12, 1'b0);
        check("R12 sum cleared by reset", result, 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule